// File: doc/BRIEF.md
# Shared-Bus Arbiter with Preference and Lockout

This block decides which of five masters owns a shared system bus: four I/O requesters (an expansion bus, a core I/O bus and two graphics/system-bus slots) and the CPU. At most one master is granted at a time. The owner keeps the bus until it pulses `done`. If the owner holds the bus longer than a programmable number of clocks, the block takes the bus back and flags a timeout.

Software controls the block through one 32-bit control word. Each I/O requester has a lockout (deny) bit and a preference bit. The CPU has a preference bit only. The top bits hold the timeout limit. After reset every I/O requester is locked out, so software has to clear the deny bits before any I/O master can get the bus.

A preferred master wins every second arbitration when it is asking. All other arbitrations serve the unlocked, non-preferred I/O requesters in round-robin order. The CPU gets the bus when none of them is eligible.

Top module: `bus_pref_arbiter`

## Requirements
- R1: At most one of `gnt_io[3:0]` and `gnt_cpu` is high in any cycle. A grant stays unchanged until the owner releases the bus or a timeout occurs.
- R2: Control word layout, read back on `cfg_rdata` from the cycle after a write:
  - bit 2i is the deny bit of I/O requester i.
  - bit 2i+1 is the preference bit of I/O requester i.
  - bit 9 is the CPU preference bit.
  - bits 31:19 hold the timeout limit in clocks.
  - every other bit reads 0.
- R3: A write that sets more than one preference bit stores only the lowest-numbered of them. It also sets `pref_err`, which stays high until reset.
- R4: After reset `cfg_rdata` reads 0xFFF80055: all deny bits are 1, all preference bits are 0, and the limit is all ones. All grants, `pref_err` and `tmo_pulse` are 0.
- R5: An I/O requester whose deny bit is 1 is never granted.
- R6: On a non-preference turn, eligible non-preferred I/O requesters are served in round-robin order. The search starts at the index after the last requester won on such a turn. After reset the first requester served this way is 0.
- R7: The CPU is granted on a non-preference turn only when no eligible non-preferred I/O requester is asking.
- R8: When the preferred master is asking, it wins every other arbitration. The turn after any preferred win is a non-preference turn, and the turn after any other win is a preference turn.
- R9: `done`, sampled while a grant is held, clears the grant at that clock edge. A new grant can appear at the following edge.
- R10: With a limit L greater than 0, a grant held without `done` stays high for exactly L cycles. It is then cleared, and `tmo_pulse` is high for one cycle in the cycle the grant is low. L = 0 disables the timeout.
- R11: `any_pref` is the OR of the control-word bits under mask 0x02AA. `any_deny` is the OR of the bits under mask 0x0055.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_io | input | 4 | Bus requests from the four I/O requesters |
| req_cpu | input | 1 | Bus request from the CPU |
| done | input | 1 | Current owner releases the bus |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Stored control word |
| gnt_io | output | 4 | One-hot grants to the I/O requesters |
| gnt_cpu | output | 1 | Grant to the CPU |
| any_pref | output | 1 | A preference bit is set |
| any_deny | output | 1 | A deny bit is set |
| pref_err | output | 1 | Sticky flag: an illegal preference write was seen |
| tmo_pulse | output | 1 | One-cycle pulse when a grant is revoked by timeout |

## Verification
A corrupted round-robin pointer shows up at the next non-preference grant: the wrong requester wins, so the bench walks complete service orders. A preference-turn flag stuck in either state breaks the strict alternation within two grants. A wrong tenure count moves the grant drop and `tmo_pulse` by one or more cycles, so both are checked on exact cycles. Legalization faults appear on `cfg_rdata` one cycle after the write.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} arb_state_t;
endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg #(
  parameter int N_IO  = 4,
  parameter int DW    = 32,
  parameter int TMO_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     ctrl_q,
  output logic [N_IO-1:0]   deny_vec,
  output logic [N_IO:0]     pref_vec,
  output logic [TMO_W-1:0]  limit,
  output logic              err_q
);
  localparam int CPU_BIT = 2*N_IO + 1;
  localparam int TMO_LSB = DW - TMO_W;

  logic [N_IO:0] pref_raw, pref_keep;
  logic          multi;
  logic [DW-1:0] next_word, rst_word;

  always_comb begin
    for (int i = 0; i < N_IO; i++) pref_raw[i] = wdata[2*i+1];
    pref_raw[N_IO] = wdata[CPU_BIT];
    pref_keep = pref_raw & (~pref_raw + 1'b1);
    multi     = (pref_raw & (pref_raw - 1'b1)) != '0;
  end

  always_comb begin
    next_word = '0;
    rst_word  = '0;
    for (int i = 0; i < N_IO; i++) begin
      next_word[2*i]   = wdata[2*i];
      next_word[2*i+1] = pref_keep[i];
      rst_word[2*i]    = 1'b1;
    end
    next_word[CPU_BIT] = pref_keep[N_IO];
    next_word[DW-1:TMO_LSB] = wdata[DW-1:TMO_LSB];
    rst_word[DW-1:TMO_LSB]  = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= rst_word;
      err_q  <= 1'b0;
    end else if (we) begin
      ctrl_q <= next_word;
      if (multi) err_q <= 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < N_IO; i++) begin
      deny_vec[i] = ctrl_q[2*i];
      pref_vec[i] = ctrl_q[2*i+1];
    end
    pref_vec[N_IO] = ctrl_q[CPU_BIT];
    limit = ctrl_q[DW-1:TMO_LSB];
  end
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N_IO = 4,
  localparam int LW  = (N_IO > 1) ? $clog2(N_IO) : 1
) (
  input  logic [N_IO:0]   eligible,
  input  logic [N_IO:0]   pref_vec,
  input  logic            pref_turn,
  input  logic [LW-1:0]   last_io,
  output logic [N_IO:0]   win,
  output logic            win_pref,
  output logic            rr_used,
  output logic [LW-1:0]   win_idx
);
  logic [N_IO:0]   pref_hit, cand;
  logic [N_IO-1:0] io_cand;
  int              j;

  always_comb begin
    pref_hit = eligible & pref_vec;
    cand     = eligible & ~pref_vec;
    io_cand  = cand[N_IO-1:0];
    win      = '0;
    win_pref = 1'b0;
    rr_used  = 1'b0;
    win_idx  = '0;
    j        = 0;
    if (pref_turn && (pref_hit != '0)) begin
      win      = pref_hit;
      win_pref = 1'b1;
    end else begin
      for (int off = 1; off <= N_IO; off++) begin
        j = int'(last_io) + off;
        if (j >= N_IO) j = j - N_IO;
        if (!rr_used && io_cand[j]) begin
          rr_used    = 1'b1;
          win_idx    = LW'(j);
          win[j]     = 1'b1;
        end
      end
      if (!rr_used) begin
        if (cand[N_IO]) begin
          win[N_IO] = 1'b1;
        end else if (pref_hit != '0) begin
          win      = pref_hit;
          win_pref = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/arb_tenure_timer.sv
module arb_tenure_timer #(
  parameter int TMO_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] cnt;
  logic [TMO_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + 1'b1;
  assign expire   = run && (limit != '0) && (cnt_next == {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || start) cnt <= '0;
    else if (run)     cnt <= cnt_next[TMO_W-1:0];
  end
endmodule

// File: rtl/bus_pref_arbiter.sv
module bus_pref_arbiter #(
  parameter int N_IO  = 4,
  parameter int DW    = 32,
  parameter int TMO_W = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IO-1:0] req_io,
  input  logic            req_cpu,
  input  logic            done,
  input  logic            cfg_we,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  output logic [N_IO-1:0] gnt_io,
  output logic            gnt_cpu,
  output logic            any_pref,
  output logic            any_deny,
  output logic            pref_err,
  output logic            tmo_pulse
);
  import arb_pkg::*;
  localparam int LW = (N_IO > 1) ? $clog2(N_IO) : 1;

  logic [N_IO-1:0]  deny_vec;
  logic [N_IO:0]    pref_vec, eligible, win, gnt_q;
  logic [TMO_W-1:0] limit;
  logic             win_pref, rr_used, expire, pref_turn, tmo_q, start;
  logic [LW-1:0]    win_idx, last_io;
  arb_state_t       state;

  arb_cfg_reg #(.N_IO(N_IO), .DW(DW), .TMO_W(TMO_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .ctrl_q(cfg_rdata), .deny_vec(deny_vec), .pref_vec(pref_vec),
    .limit(limit), .err_q(pref_err)
  );

  assign eligible = {req_cpu, req_io & ~deny_vec};

  arb_pick #(.N_IO(N_IO)) u_pick (
    .eligible(eligible), .pref_vec(pref_vec), .pref_turn(pref_turn),
    .last_io(last_io), .win(win), .win_pref(win_pref),
    .rr_used(rr_used), .win_idx(win_idx)
  );

  assign start = (state == ST_IDLE) && (win != '0);

  arb_tenure_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst(rst), .start(start),
    .run((state == ST_BUSY) && !done), .limit(limit), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      gnt_q     <= '0;
      pref_turn <= 1'b1;
      last_io   <= LW'(N_IO - 1);
      tmo_q     <= 1'b0;
    end else begin
      tmo_q <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          gnt_q     <= win;
          state     <= ST_BUSY;
          pref_turn <= !win_pref;
          if (rr_used) last_io <= win_idx;
        end
      end else if (done) begin
        gnt_q <= '0;
        state <= ST_IDLE;
      end else if (expire) begin
        gnt_q <= '0;
        tmo_q <= 1'b1;
        state <= ST_IDLE;
      end
    end
  end

  assign gnt_io    = gnt_q[N_IO-1:0];
  assign gnt_cpu   = gnt_q[N_IO];
  assign tmo_pulse = tmo_q;
  assign any_pref  = |pref_vec;
  assign any_deny  = |deny_vec;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N_IO  = 4,
  parameter int DW    = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            done,
  input logic [DW-1:0]   cfg_rdata,
  input logic [N_IO-1:0] gnt_io,
  input logic            gnt_cpu,
  input logic            pref_err,
  input logic            tmo_pulse
);
  logic [N_IO:0]   g, pv;
  logic [N_IO-1:0] dv;

  always_comb begin
    g = {gnt_cpu, gnt_io};
    for (int i = 0; i < N_IO; i++) begin
      dv[i] = cfg_rdata[2*i];
      pv[i] = cfg_rdata[2*i+1];
    end
    pv[N_IO] = cfg_rdata[2*N_IO+1];
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(g)); // R1
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((g != '0) && !done) |=> (tmo_pulse || $stable(g))); // R1
  AST_PREF_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(pv)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) pref_err |=> pref_err); // R3
  AST_RST_DENY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dv == '1 && pv == '0)); // R4
  AST_DENY_BLOCK: assert property (@(posedge clk) disable iff (rst)
    ((gnt_io & ~$past(gnt_io) & $past(dv)) == '0)); // R5
  AST_TMO_NOGNT: assert property (@(posedge clk) disable iff (rst) tmo_pulse |-> (g == '0)); // R10
  AST_TMO_ONE: assert property (@(posedge clk) disable iff (rst) tmo_pulse |=> !tmo_pulse); // R10
endmodule

bind bus_pref_arbiter arb_checker #(.N_IO(N_IO), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .done(done), .cfg_rdata(cfg_rdata),
  .gnt_io(gnt_io), .gnt_cpu(gnt_cpu), .pref_err(pref_err), .tmo_pulse(tmo_pulse)
);

// File: tb/sim_bus_pref_arbiter.sv
module sim_bus_pref_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] LIM1000 = 32'd1000 << 19;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  req_io = '0;
  logic        req_cpu = 1'b0, done = 1'b0, cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  gnt_io;
  logic        gnt_cpu, any_pref, any_deny, pref_err, tmo_pulse;
  int          n_chk = 0, n_bad = 0;
  bit          closed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_pref_arbiter u0 (
    .clk(clk), .rst(rst), .req_io(req_io), .req_cpu(req_cpu), .done(done),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .gnt_io(gnt_io), .gnt_cpu(gnt_cpu), .any_pref(any_pref),
    .any_deny(any_deny), .pref_err(pref_err), .tmo_pulse(tmo_pulse)
  );

  function automatic logic [4:0] gv();
    return {gnt_cpu, gnt_io};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic serve(logic [4:0] now, logic [4:0] nxt);
    chk("R1 owner", 32'(gv()), 32'(now));
    done = 1'b1;
    @(negedge clk);
    chk("R9 release", 32'(gv()), 32'h0);
    done = 1'b0;
    @(negedge clk);
    chk("R6 R7 R8 next winner", 32'(gv()), 32'(nxt));
  endtask

  task automatic t_reset();
    chk("R4 cfg", cfg_rdata, 32'hFFF80055);
    chk("R4 grants", 32'(gv()), 32'h0);
    chk("R4 err", 32'(pref_err), 32'h0);
    chk("R4 tmo", 32'(tmo_pulse), 32'h0);
    chk("R11 any_deny", 32'(any_deny), 32'h1);
    chk("R11 any_pref", 32'(any_pref), 32'h0);
  endtask

  task automatic t_locked();
    req_io = 4'hF;
    repeat (4) @(negedge clk);
    chk("R5 locked out", 32'(gv()), 32'h0);
    req_cpu = 1'b1;
    @(negedge clk);
    chk("R7 cpu alone", 32'(gv()), 32'h10);
    req_cpu = 1'b0;
    serve(5'h10, 5'h00);
    req_io = 4'h0;
  endtask

  task automatic t_round_robin();
    wr(LIM1000);
    chk("R2 readback", cfg_rdata, LIM1000);
    chk("R11 any_deny clear", 32'(any_deny), 32'h0);
    req_io = 4'hF; req_cpu = 1'b1;
    @(negedge clk);
    chk("R6 first", 32'(gv()), 32'h01);
    serve(5'h01, 5'h02);
    serve(5'h02, 5'h04);
    serve(5'h04, 5'h08);
    serve(5'h08, 5'h01);
    req_io = 4'h0;
    serve(5'h01, 5'h10);
    req_cpu = 1'b0;
    serve(5'h10, 5'h00);
  endtask

  task automatic t_partial_deny();
    wr(LIM1000 | 32'h1);
    req_io = 4'h3;
    @(negedge clk);
    chk("R5 skip denied", 32'(gv()), 32'h02);
    serve(5'h02, 5'h02);
    req_io = 4'h0;
    serve(5'h02, 5'h00);
  endtask

  task automatic t_pref();
    wr(LIM1000 | 32'h20);
    chk("R11 any_pref", 32'(any_pref), 32'h1);
    req_io = 4'hF;
    @(negedge clk);
    chk("R8 pref first", 32'(gv()), 32'h04);
    serve(5'h04, 5'h08);
    serve(5'h08, 5'h04);
    serve(5'h04, 5'h01);
    serve(5'h01, 5'h04);
    serve(5'h04, 5'h02);
    req_io = 4'h0;
    serve(5'h02, 5'h00);
  endtask

  task automatic t_illegal();
    wr(LIM1000 | 32'h282);
    chk("R3 lowest kept", cfg_rdata, LIM1000 | 32'h2);
    chk("R3 err set", 32'(pref_err), 32'h1);
    wr(LIM1000);
    chk("R3 err sticky", 32'(pref_err), 32'h1);
    wr(32'hFFFFFFFF);
    chk("R2 R3 unused bits zero", cfg_rdata, 32'hFFF80057);
  endtask

  task automatic t_timeout();
    bit seen = 0;
    wr(32'd3 << 19);
    req_io = 4'h1;
    @(negedge clk);
    chk("R10 grant c1", 32'(gv()), 32'h01);
    @(negedge clk);
    chk("R10 grant c2", 32'(gv()), 32'h01);
    @(negedge clk);
    chk("R10 grant c3", 32'(gv()), 32'h01);
    chk("R10 no early tmo", 32'(tmo_pulse), 32'h0);
    @(negedge clk);
    chk("R10 dropped", 32'(gv()), 32'h0);
    chk("R10 pulse", 32'(tmo_pulse), 32'h1);
    @(negedge clk);
    chk("R10 pulse one cycle", 32'(tmo_pulse), 32'h0);
    chk("R10 rearbitrated", 32'(gv()), 32'h01);
    req_io = 4'h0;
    serve(5'h01, 5'h00);
    wr(32'h0);
    req_io = 4'h1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tmo_pulse) seen = 1;
    end
    chk("R10 limit zero no tmo", 32'(seen), 32'h0);
    req_io = 4'h0;
    serve(5'h01, 5'h00);
  endtask

  task automatic summary();
    if (!closed) begin
      closed = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_locked();
    t_round_robin();
    t_partial_deny();
    t_pref();
    t_illegal();
    t_timeout();
    summary();
    $finish;
  end
endmodule